// File: doc/BRIEF.md
# Data-Space Router with Core I/O Registers

This block sits between the load/store unit of an 8-bit core and the places a byte can live. Every request carries an address and a flag that says whether it is a data-space access or a direct I/O port access. The router sends it to one of three destinations. Low data addresses reach the general register file through a small read/write port. The following window of data addresses, and every direct port access, lands in I/O space. All remaining addresses are passed to an external memory bus.

Inside I/O space the top eight ports are not forwarded. They are served by registers held in the router itself: four optional extended-address bytes, an always-present jump-extension byte, the two halves of the stack pointer and a pass-through to the status-flag logic. Each extended byte is presented as a 24-bit value with the byte in bits 23:16. The state machine has two states. `ST_IDLE` accepts requests. Register-file and local accesses finish in the same cycle, and a bus-bound request takes the transition `ST_IDLE -> ST_BUS`. `ST_BUS` holds the bus request until `bus_ready`, delivers the read byte, and returns through `ST_BUS -> ST_IDLE`.

Top module: `dspace_router`

## Requirements
- R1: A data access with address below 32 goes to the register file. It drives `gpr_idx` with the address, and a write pulses `gpr_we` in the accepting cycle. A read returns `gpr_rdata`.
- R2: A data address in 32..95 selects I/O port (address - 32). A direct port access (`req_io`=1) uses only `req_addr[5:0]` as the port number.
- R3: Data addresses of 96 and above go to the bus unchanged. I/O ports 0x00..0x37 also go to the bus, at address port + 32.
- R4: Ports 0x38..0x3F are local: 0x38..0x3B are extended-address bytes D, X, Y, Z, 0x3C is the jump-extension byte, 0x3D and 0x3E are the stack pointer low and high bytes, and 0x3F is the status flags. A local extended byte is output with the written byte in bits 23:16 and zeros below, and a read returns that byte.
- R5: Each of the four optional extended bytes is enabled by bit n of `XREG_EN` (bit 0 = D … bit 3 = Z). When disabled it reads as zero and writes to it are ignored. The jump-extension byte is always writable.
- R6: A write to port 0x3D replaces only `sp_q[7:0]`. A write to port 0x3E changes `sp_q[15:8]` only when `SP_TWO_BYTE`=1. Reads of 0x3D/0x3E return the low/high byte.
- R7: A write to port 0x3F pulses `flg_we` with the byte on `flg_wdata`, and a read of 0x3F returns `flg_rdata`.
- R8: Only `req_wdata[7:0]` is stored or forwarded. Higher bits of the write data have no effect.
- R9: A bus request holds `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` steady until `bus_ready`. `req_ready` is low meanwhile. `rsp_valid` rises with `bus_rdata` in the cycle `bus_ready` is high.
- R10: Register-file and local accesses raise `rsp_valid` in the cycle they are accepted.
- R11: After reset all extended bytes and the stack pointer are zero, `req_ready` is high and `bus_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_io | input | 1 | 1 = direct I/O port access, 0 = data-space access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Data address or port number |
| req_wdata | input | IN_W | Write data; low byte used |
| rsp_valid | output | 1 | Response (read byte) valid |
| rsp_rdata | output | 8 | Read byte |
| gpr_we | output | 1 | Register-file write strobe |
| gpr_idx | output | log2(GPR_N) | Register-file index |
| gpr_wdata | output | 8 | Register-file write byte |
| gpr_rdata | input | 8 | Register-file read byte (combinational) |
| flg_we | output | 1 | Status-flag write strobe |
| flg_wdata | output | 8 | Status-flag write byte |
| flg_rdata | input | 8 | Current status flags |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | Bus request is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 8 | Bus write byte |
| bus_ready | input | 1 | Bus completes the request |
| bus_rdata | input | 8 | Bus read byte |
| xd_q | output | 24 | Extended data byte (bits 23:16) |
| xx_q | output | 24 | Extended X byte |
| xy_q | output | 24 | Extended Y byte |
| xz_q | output | 24 | Extended Z byte |
| jx_q | output | 24 | Jump-extension byte |
| sp_q | output | 16 | Stack pointer |

## Verification
On every cycle the assertions check three things: at most one of register-file write, flag write and bus request is active at a time, a pending bus request keeps its fields steady until accepted, and a bus request only ever follows an accepted request. They also check that a stack-low write leaves the high byte alone, that an enabled extended byte changes only when written, and that a one-byte stack pointer keeps its high byte at zero. The address-window boundaries, the mapping of each local port, the masking of write data, the read-back of disabled bytes and the returned bus data need the bench. It runs a reference model over random and directed accesses, with two parameter sets.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    typedef enum logic [1:0] {
        TGT_GPR   = 2'd0,
        TGT_LOCAL = 2'd1,
        TGT_BUS   = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } st_e;

    // local register selector = port number minus the first local port
    localparam logic [2:0] SEL_XD  = 3'd0;
    localparam logic [2:0] SEL_XX  = 3'd1;
    localparam logic [2:0] SEL_XY  = 3'd2;
    localparam logic [2:0] SEL_XZ  = 3'd3;
    localparam logic [2:0] SEL_JX  = 3'd4;
    localparam logic [2:0] SEL_SPL = 3'd5;
    localparam logic [2:0] SEL_SPH = 3'd6;
    localparam logic [2:0] SEL_FLG = 3'd7;

    localparam int unsigned N_XREG = 5;
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
    import dsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned GPR_N  = 32,
    parameter int unsigned IO_N   = 64
) (
    input  logic                     is_io,
    input  logic [ADDR_W-1:0]        addr,
    output tgt_e                     tgt,
    output logic [$clog2(GPR_N)-1:0] gpr_idx,
    output logic [2:0]               loc_sel,
    output logic [ADDR_W-1:0]        bus_addr
);
    localparam int unsigned GPR_W = $clog2(GPR_N);
    localparam int unsigned IO_W  = $clog2(IO_N);
    localparam int unsigned LOCAL_FIRST = IO_N - 8;

    logic [ADDR_W-1:0] off;
    logic [IO_W-1:0]   port;
    logic              hit_io;

    always_comb begin
        tgt      = TGT_BUS;
        gpr_idx  = '0;
        loc_sel  = '0;
        bus_addr = addr;
        port     = '0;
        hit_io   = 1'b0;
        off      = addr - ADDR_W'(GPR_N);
        if (is_io) begin
            hit_io = 1'b1;
            port   = addr[IO_W-1:0];
        end else if (addr < ADDR_W'(GPR_N)) begin
            tgt     = TGT_GPR;
            gpr_idx = addr[GPR_W-1:0];
        end else if (off < ADDR_W'(IO_N)) begin
            hit_io = 1'b1;
            port   = off[IO_W-1:0];
        end
        if (hit_io) begin
            bus_addr = ADDR_W'(port) + ADDR_W'(GPR_N);
            if (port >= IO_W'(LOCAL_FIRST)) begin
                tgt     = TGT_LOCAL;
                loc_sel = port[2:0];
            end
        end
    end
endmodule

// File: rtl/dsr_core_regs.sv
module dsr_core_regs
    import dsr_pkg::*;
#(
    parameter logic [3:0] XREG_EN     = 4'b1110,
    parameter bit         SP_TWO_BYTE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [2:0]                 sel,
    input  logic [7:0]                 wdata,
    input  logic [7:0]                 flg_rdata,
    output logic [7:0]                 rdata,
    output logic                       flg_we,
    output logic [7:0]                 flg_wdata,
    output logic [N_XREG-1:0][23:0]    ext_q,
    output logic [15:0]                sp_q
);
    logic [N_XREG-1:0][7:0] xbyte;

    for (genvar g = 0; g < N_XREG; g++) begin : g_xreg
        if (g == N_XREG - 1 || XREG_EN[g % 4]) begin : g_on
            always_ff @(posedge clk) begin
                if (!rst_n)
                    xbyte[g] <= '0;
                else if (we && sel == 3'(g))
                    xbyte[g] <= wdata;
            end
            assert_xreg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && sel == 3'(g)) |=> $stable(ext_q[g]))
                else $error("extended byte %0d changed without a write", g);
        end else begin : g_off
            assign xbyte[g] = '0;
        end
        assign ext_q[g] = {xbyte[g], 16'h0000};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (we) begin
            if (sel == SEL_SPL)
                sp_q[7:0] <= wdata;
            if (sel == SEL_SPH && SP_TWO_BYTE)
                sp_q[15:8] <= wdata;
        end
    end

    assign flg_we    = we && (sel == SEL_FLG);
    assign flg_wdata = wdata;

    always_comb begin
        unique case (sel)
            SEL_XD, SEL_XX, SEL_XY, SEL_XZ, SEL_JX: rdata = ext_q[sel][23:16];
            SEL_SPL: rdata = sp_q[7:0];
            SEL_SPH: rdata = sp_q[15:8];
            default: rdata = flg_rdata;
        endcase
    end

    assert_spl_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_SPL) |=> $stable(sp_q[15:8]))
        else $error("stack low write disturbed high byte");

    if (!SP_TWO_BYTE) begin : g_sp_narrow
        assert_sph_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sp_q[15:8] == 8'h00)
            else $error("one-byte stack pointer gained a high byte");
    end
endmodule

// File: rtl/dsr_bus_fsm.sv
module dsr_bus_fsm
    import dsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  tgt_e              tgt,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic [7:0]        wdata8,
    input  logic [7:0]        near_rdata,
    input  logic              bus_ready,
    input  logic [7:0]        bus_rdata,
    output logic              req_ready,
    output logic              near_fire,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata
);
    st_e               state, state_nx;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_wdata;
    logic              lat_write;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
        end else if (state == ST_IDLE && req_valid && tgt == TGT_BUS) begin
            lat_addr  <= dec_addr;
            lat_wdata <= wdata8;
            lat_write <= req_write;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid && tgt == TGT_BUS) state_nx = ST_BUS;
            ST_BUS:  if (bus_ready) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        near_fire = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        bus_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && tgt != TGT_BUS) begin
                    near_fire = 1'b1;
                    rsp_valid = 1'b1;
                    rsp_rdata = near_rdata;
                end
            end
            ST_BUS: begin
                bus_valid = 1'b1;
                if (bus_ready) begin
                    rsp_valid = 1'b1;
                    rsp_rdata = bus_rdata;
                end
            end
        endcase
    end

    assign bus_addr  = lat_addr;
    assign bus_wdata = lat_wdata;
    assign bus_write = lat_write;

    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)
            && $stable(bus_wdata) && $stable(bus_write)))
        else $error("bus request dropped or changed before ready");

    assert_bus_from_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(req_valid))
        else $error("bus request without an accepted access");
endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dsr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned IN_W        = 16,
    parameter int unsigned GPR_N       = 32,
    parameter int unsigned IO_N        = 64,
    parameter logic [3:0]  XREG_EN     = 4'b1110,
    parameter bit          SP_TWO_BYTE = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_io,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [IN_W-1:0]          req_wdata,
    output logic                     rsp_valid,
    output logic [7:0]               rsp_rdata,
    output logic                     gpr_we,
    output logic [$clog2(GPR_N)-1:0] gpr_idx,
    output logic [7:0]               gpr_wdata,
    input  logic [7:0]               gpr_rdata,
    output logic                     flg_we,
    output logic [7:0]               flg_wdata,
    input  logic [7:0]               flg_rdata,
    output logic                     bus_valid,
    output logic                     bus_write,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [7:0]               bus_wdata,
    input  logic                     bus_ready,
    input  logic [7:0]               bus_rdata,
    output logic [23:0]              xd_q,
    output logic [23:0]              xx_q,
    output logic [23:0]              xy_q,
    output logic [23:0]              xz_q,
    output logic [23:0]              jx_q,
    output logic [15:0]              sp_q
);
    tgt_e                   tgt;
    logic [2:0]             loc_sel;
    logic [ADDR_W-1:0]      dec_addr;
    logic [7:0]             wdata8;
    logic [7:0]             loc_rdata;
    logic [7:0]             near_rdata;
    logic                   near_fire;
    logic                   loc_we;
    logic [N_XREG-1:0][23:0] ext_q;

    assign wdata8 = req_wdata[7:0];

    dsr_decode #(.ADDR_W(ADDR_W), .GPR_N(GPR_N), .IO_N(IO_N)) u_decode (
        .is_io    (req_io),
        .addr     (req_addr),
        .tgt      (tgt),
        .gpr_idx  (gpr_idx),
        .loc_sel  (loc_sel),
        .bus_addr (dec_addr)
    );

    assign near_rdata = (tgt == TGT_GPR) ? gpr_rdata : loc_rdata;

    dsr_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tgt        (tgt),
        .dec_addr   (dec_addr),
        .wdata8     (wdata8),
        .near_rdata (near_rdata),
        .bus_ready  (bus_ready),
        .bus_rdata  (bus_rdata),
        .req_ready  (req_ready),
        .near_fire  (near_fire),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata)
    );

    assign gpr_we    = near_fire && req_write && (tgt == TGT_GPR);
    assign gpr_wdata = wdata8;
    assign loc_we    = near_fire && req_write && (tgt == TGT_LOCAL);

    dsr_core_regs #(.XREG_EN(XREG_EN), .SP_TWO_BYTE(SP_TWO_BYTE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (loc_we),
        .sel       (loc_sel),
        .wdata     (wdata8),
        .flg_rdata (flg_rdata),
        .rdata     (loc_rdata),
        .flg_we    (flg_we),
        .flg_wdata (flg_wdata),
        .ext_q     (ext_q),
        .sp_q      (sp_q)
    );

    assign xd_q = ext_q[0];
    assign xx_q = ext_q[1];
    assign xy_q = ext_q[2];
    assign xz_q = ext_q[3];
    assign jx_q = ext_q[4];

    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gpr_we, flg_we, bus_valid}))
        else $error("more than one destination active");
endmodule

// File: tb/dspace_router_bench.sv
module dspace_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] XEN = 4'b1110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_io = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        bus_ready = 1'b0;
    logic [7:0]  bus_rdata = '0, flg_rdata = '0;
    logic [7:0]  gpr_rdata;

    logic        req_ready, rsp_valid, gpr_we, flg_we, bus_valid, bus_write;
    logic [7:0]  rsp_rdata, gpr_wdata, flg_wdata, bus_wdata;
    logic [4:0]  gpr_idx;
    logic [15:0] bus_addr, sp_q;
    logic [23:0] xd_q, xx_q, xy_q, xz_q, jx_q;

    logic        n_rr, n_rv, n_gw, n_fw, n_bv, n_bw;
    logic [7:0]  n_rd, n_gd, n_fd, n_bd;
    logic [4:0]  n_gi;
    logic [15:0] n_ba, n_sp;
    logic [23:0] n_xd, n_xx, n_xy, n_xz, n_jx;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign gpr_rdata = {3'b000, gpr_idx} * 8'd7 + 8'd3;

    dspace_router #(.XREG_EN(XEN), .SP_TWO_BYTE(1'b1)) u_dspace_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_io(req_io), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
        .gpr_wdata(gpr_wdata), .gpr_rdata(gpr_rdata), .flg_we(flg_we), .flg_wdata(flg_wdata),
        .flg_rdata(flg_rdata), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .xd_q(xd_q), .xx_q(xx_q), .xy_q(xy_q), .xz_q(xz_q), .jx_q(jx_q), .sp_q(sp_q));

    dspace_router #(.XREG_EN(4'b1111), .SP_TWO_BYTE(1'b0)) u_narrow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_rr),
        .req_io(req_io), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(n_rv), .rsp_rdata(n_rd), .gpr_we(n_gw), .gpr_idx(n_gi),
        .gpr_wdata(n_gd), .gpr_rdata(gpr_rdata), .flg_we(n_fw), .flg_wdata(n_fd),
        .flg_rdata(flg_rdata), .bus_valid(n_bv), .bus_write(n_bw), .bus_addr(n_ba),
        .bus_wdata(n_bd), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .xd_q(n_xd), .xx_q(n_xx), .xy_q(n_xy), .xz_q(n_xz), .jx_q(n_jx), .sp_q(n_sp));

    int n_chk = 0, n_bad = 0;
    logic [7:0]  m_x [5];
    logic [15:0] m_sp = '0, m_spn = '0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xval(input int s);
        if (s < 4 && !XEN[s]) return 8'h00;
        return m_x[s];
    endfunction

    function automatic logic [7:0] local_read(input int s);
        case (s)
            5: return m_sp[7:0];
            6: return m_sp[15:8];
            7: return flg_rdata;
            default: return xval(s);
        endcase
    endfunction

    task automatic classify(input bit io, input int addr, output int kind,
                            output int idx, output int sel, output int baddr);
        int p;
        bit isport = 1'b0;
        kind = 2; idx = 0; sel = 0; baddr = addr; p = 0;
        if (io) begin p = addr % 64; isport = 1'b1; end
        else if (addr < 32) begin kind = 0; idx = addr; end
        else if (addr < 96) begin p = addr - 32; isport = 1'b1; end
        if (isport) begin
            baddr = p + 32;
            if (p >= 56) begin kind = 1; sel = p - 56; end
        end
    endtask

    task automatic check_regs();
        chk(xd_q == {xval(0), 16'h0}, "R5 xd_q", xd_q, {xval(0), 16'h0});
        chk(xx_q == {xval(1), 16'h0}, "R4 xx_q", xx_q, {xval(1), 16'h0});
        chk(xy_q == {xval(2), 16'h0}, "R4 xy_q", xy_q, {xval(2), 16'h0});
        chk(xz_q == {xval(3), 16'h0}, "R4 xz_q", xz_q, {xval(3), 16'h0});
        chk(jx_q == {xval(4), 16'h0}, "R5 jx_q", jx_q, {xval(4), 16'h0});
        chk(sp_q == m_sp, "R6 sp_q", sp_q, m_sp);
        chk(n_sp == m_spn, "R6 narrow sp_q", n_sp, m_spn);
    endtask

    task automatic do_op(input bit io, input bit wr, input int addr,
                         input logic [15:0] wd, input int waits);
        int kind, idx, sel, baddr;
        logic [7:0] brd;
        classify(io, addr, kind, idx, sel, baddr);
        @(negedge clk);
        flg_rdata = 8'($urandom);
        req_valid = 1'b1; req_io = io; req_write = wr;
        req_addr = 16'(addr); req_wdata = wd;
        #1;
        if (kind == 0) begin
            chk(rsp_valid, "R10 gpr rsp_valid", rsp_valid, 1);
            chk(gpr_we == wr, "R1 gpr_we", gpr_we, wr);
            chk(gpr_idx == 5'(idx), "R1 gpr_idx", gpr_idx, idx);
            if (wr) chk(gpr_wdata == wd[7:0], "R8 gpr_wdata", gpr_wdata, wd[7:0]);
            else chk(rsp_rdata == 8'(idx * 7 + 3), "R1 gpr read", rsp_rdata, 8'(idx * 7 + 3));
        end else if (kind == 1) begin
            chk(rsp_valid, "R10 local rsp_valid", rsp_valid, 1);
            chk(flg_we == (wr && sel == 7), "R7 flg_we", flg_we, wr && sel == 7);
            if (wr && sel == 7) chk(flg_wdata == wd[7:0], "R7 flg_wdata", flg_wdata, wd[7:0]);
            if (!wr) chk(rsp_rdata == local_read(sel), "R4 local read", rsp_rdata, local_read(sel));
            chk(!bus_valid, "R2 local not on bus", bus_valid, 0);
        end else begin
            chk(!rsp_valid, "R9 no early rsp", rsp_valid, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == 1 && wr) begin
            if (sel < 5) m_x[sel] = wd[7:0];
            else if (sel == 5) begin m_sp[7:0] = wd[7:0]; m_spn[7:0] = wd[7:0]; end
            else if (sel == 6) m_sp[15:8] = wd[7:0];
        end
        if (kind == 2) begin
            for (int w = 0; w <= waits; w++) begin
                #1;
                chk(bus_valid, "R9 bus_valid held", bus_valid, 1);
                chk(bus_addr == 16'(baddr), "R3 bus_addr", bus_addr, baddr);
                chk(bus_write == wr, "R9 bus_write", bus_write, wr);
                if (wr) chk(bus_wdata == wd[7:0], "R8 bus_wdata", bus_wdata, wd[7:0]);
                chk(!req_ready, "R9 req_ready low", req_ready, 0);
                if (w < waits) @(negedge clk);
            end
            brd = 8'($urandom);
            bus_ready = 1'b1; bus_rdata = brd;
            #1;
            chk(rsp_valid, "R9 rsp_valid on ready", rsp_valid, 1);
            if (!wr) chk(rsp_rdata == brd, "R9 bus read data", rsp_rdata, brd);
            @(negedge clk);
            bus_ready = 1'b0;
            #1;
            chk(!bus_valid && req_ready, "R9 back to idle", bus_valid, 0);
        end else begin
            #1;
            check_regs();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) m_x[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !bus_valid, "R11 idle after reset", {req_ready, bus_valid}, 2'b10);
        check_regs();
        rst_n = 1'b1;

        // directed: every local port through data addresses, upper write bits set
        for (int p = 56; p < 64; p++) do_op(1'b0, 1'b1, p + 32, 16'hA500 | 16'(p * 3 + 1), 0);
        for (int p = 56; p < 64; p++) do_op(1'b1, 1'b0, p, 16'h0, 0);
        // R2: direct port access ignores upper address bits
        do_op(1'b1, 1'b1, 16'hFF00 | 16'h3D, 16'h7742, 0);
        do_op(1'b1, 1'b0, 16'h8000 | 16'h3E, 16'h0, 0);
        // window boundaries
        do_op(1'b0, 1'b0, 31, 0, 0);
        do_op(1'b0, 1'b1, 32, 16'h1234, 1);
        do_op(1'b0, 1'b0, 87, 0, 2);
        do_op(1'b0, 1'b0, 95, 0, 0);
        do_op(1'b0, 1'b1, 96, 16'hFFEE, 0);
        do_op(1'b0, 1'b0, 65535, 0, 3);
        do_op(1'b1, 1'b0, 55, 0, 1);
        do_op(1'b0, 1'b1, 0, 16'hBEEF, 0);

        for (int n = 0; n < 600; n++) begin
            int r, a;
            bit io;
            r = int'($urandom % 5);
            io = (r == 4);
            case (r)
                0: a = int'($urandom % 32);
                1: a = 32 + int'($urandom % 64);
                2: a = 88 + int'($urandom % 8);
                3: a = 96 + int'($urandom % (65536 - 96));
                default: a = int'($urandom % 65536);
            endcase
            do_op(io, 1'($urandom), a, 16'($urandom), int'($urandom % 4));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule